// File: doc/BRIEF.md
# Selector Rights Verification Unit

This unit answers one of four queries about a segment selector without ever raising a fault. The four queries are: read the access rights, verify read permission, verify write permission, and read the segment limit. A caller hands over the query code, the selector, the current privilege level and the byte limits of the global and local descriptor tables. The unit first checks the selector against its table. If that passes, it fetches the 8-byte descriptor through a request/response port. It then reports the outcome on a single zero-flag (`zf`). For the limit query it also returns the 32-bit limit after granularity scaling.

Queries enter over a valid/ready port. `req_ready` is high only while the unit is idle. A query is taken on the clock edge where `req_valid` and `req_ready` are both high. While a query is in progress, any presented request waits and the caller's fields may change freely. The descriptor read port follows the same rule in the other direction. `dsc_rd_valid` stays high, with a stable table bit and index, until the memory side raises `dsc_rd_ready`. After that handshake the unit waits for `dsc_rsp_valid`, which has no back-pressure. The table limits are plain inputs and must stay stable while a query is in progress. The result is marked by a one-cycle `done` pulse. `zf` and `limit_out` keep their values until the next result.

Top module: `selchk_unit`

## Requirements
- R1: `req_ready` is 1 exactly when no query is in progress. Any request presented while busy is not taken, and changes to the request fields after acceptance do not affect the result.
- R2: A selector whose index (bits 15..3) is 0 and whose table bit (bit 2) is 0 gives `zf`=0, whatever its requested level (bits 1..0). No descriptor read is issued for it.
- R3: The table bit selects the local limit when 1 and the global limit when 0. If index*8+7 exceeds the selected byte limit, the result is `zf`=0 and no descriptor read is issued. A value exactly equal to the limit passes.
- R4: A passing selector issues exactly one read, carrying the table bit and the index. `dsc_rd_valid` and the address hold until `dsc_rd_ready`. Only a response that arrives after the handshake is used.
- R5: The descriptor is decoded with limit bits 15..0 in bits 15..0 and limit bits 19..16 in bits 51..48. The type is in bits 43..40, the code/data flag (1 = code or data) is bit 44, the level is bits 46..45 and granularity is bit 55. For code/data, type bit 3 = code, bit 2 = conforming (code), and bit 1 = readable (code) or writable (data).
- R6: The rights query (op 0) accepts every code and data descriptor. It also accepts every system type except 6, 7, 14 and 15.
- R7: The limit query (op 3) accepts code and data descriptors and system types 1, 2, 3, 9 and 11. It rejects every other system type.
- R8: The read check (op 1) accepts data and readable code. The write check (op 2) accepts only writable data. Both reject all system descriptors.
- R9: Unless the descriptor is conforming code, the check passes only if the descriptor level is at least max(current level, requested level).
- R10: On success `zf`=1. For op 3, `limit_out` is the 20-bit limit when granularity is 0, or limit*4096+4095 when it is 1. `limit_out` is 0 for any failure or any other op.
- R11: `done` is a single-cycle pulse. It comes 1 cycle after acceptance on a selector failure, and 3+S+D cycles after acceptance on the fetch path. Here S is the number of cycles that `dsc_rd_ready` is withheld and D is the number of cycles from the handshake to the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Query offered |
| req_ready | output | 1 | Unit idle, can take a query |
| req_op | input | 2 | 0 rights, 1 read check, 2 write check, 3 limit |
| req_sel | input | 16 | Selector: index, table bit, requested level |
| req_cpl | input | 2 | Current privilege level |
| gtab_limit | input | 16 | Global table byte limit |
| ltab_limit | input | 16 | Local table byte limit |
| dsc_rd_valid | output | 1 | Descriptor read request |
| dsc_rd_ready | input | 1 | Memory takes the request |
| dsc_rd_tbl | output | 1 | Table select of the read (1 = local) |
| dsc_rd_idx | output | 13 | Descriptor index of the read |
| dsc_rsp_valid | input | 1 | Descriptor data valid |
| dsc_rsp_data | input | 64 | Descriptor contents |
| done | output | 1 | One-cycle result strobe |
| zf | output | 1 | Query outcome flag |
| limit_out | output | 32 | Scaled limit for a passing limit query |

## Verification
The hardest cases to reach are the read-port timing corners. These are a long `dsc_rd_ready` stall with a fast response, and a fast handshake with a slow response. In both, a response must not be taken early and the address must stay frozen. The bench places the handshake and the response at chosen cycles for each query. It predicts the exact `done` cycle from those two delays and checks the read port on every cycle in between. It also holds `req_valid` high with a changed selector throughout each query, so back-pressure and input capture are checked on every query.

// File: rtl/selchk_pkg.sv
package selchk_pkg;
  typedef enum logic [1:0] {
    OP_RIGHTS = 2'd0,
    OP_VRD    = 2'd1,
    OP_VWR    = 2'd2,
    OP_LIMIT  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_BOUND, ST_FETCH, ST_EVAL, ST_DONE
  } st_e;

  typedef struct packed {
    logic [19:0] raw_lim;
    logic        gran;
    logic [3:0]  typ;
    logic        cd;
    logic [1:0]  dpl;
  } dfld_t;

  function automatic dfld_t unpack_desc(input logic [63:0] d);
    dfld_t f;
    f.raw_lim = {d[51:48], d[15:0]};
    f.gran    = d[55];
    f.typ     = d[43:40];
    f.cd      = d[44];
    f.dpl     = d[46:45];
    return f;
  endfunction
endpackage

// File: rtl/selchk_bound.sv
module selchk_bound #(
  parameter int SEL_W = 16,
  parameter int LIM_W = 16
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [LIM_W-1:0] gtab_limit,
  input  logic [LIM_W-1:0] ltab_limit,
  output logic             ok
);
  localparam int IDX_W = SEL_W - 3;
  localparam int CW    = (SEL_W > LIM_W) ? SEL_W : LIM_W;

  logic [IDX_W-1:0] idx;
  logic             loc;
  logic [SEL_W-1:0] last_byte;
  logic [LIM_W-1:0] lim;
  logic             is_null;

  always_comb begin
    idx       = sel[SEL_W-1:3];
    loc       = sel[2];
    is_null   = (idx == '0) && !loc;
    last_byte = {idx, 3'b111};
    lim       = loc ? ltab_limit : gtab_limit;
    ok        = !is_null && (CW'(last_byte) <= CW'(lim));
  end
endmodule

// File: rtl/selchk_decode.sv
module selchk_decode
  import selchk_pkg::*;
#(
  parameter int OUT_W = 32
) (
  input  logic [1:0]       op,
  input  logic [63:0]      desc,
  input  logic [1:0]       cpl,
  input  logic [1:0]       rpl,
  output logic             pass,
  output logic [OUT_W-1:0] lim_out
);
  dfld_t      f;
  logic       is_code, is_data, is_conf;
  logic       sys_rights, sys_limit, type_ok, vis;
  logic [1:0] epl;
  logic [31:0] scaled;

  always_comb begin
    f          = unpack_desc(desc);
    is_code    = f.cd && f.typ[3];
    is_data    = f.cd && !f.typ[3];
    is_conf    = is_code && f.typ[2];
    sys_rights = !f.cd && !(f.typ inside {4'h6, 4'h7, 4'hE, 4'hF});
    sys_limit  = !f.cd && (f.typ inside {4'h1, 4'h2, 4'h3, 4'h9, 4'hB});
    unique case (op_e'(op))
      OP_RIGHTS: type_ok = f.cd || sys_rights;
      OP_VRD:    type_ok = is_data || (is_code && f.typ[1]);
      OP_VWR:    type_ok = is_data && f.typ[1];
      default:   type_ok = f.cd || sys_limit;
    endcase
    epl     = (cpl > rpl) ? cpl : rpl;
    vis     = is_conf || (f.dpl >= epl);
    pass    = type_ok && vis;
    scaled  = f.gran ? {f.raw_lim, 12'hFFF} : {12'h000, f.raw_lim};
    lim_out = (pass && (op_e'(op) == OP_LIMIT)) ? OUT_W'(scaled) : '0;
  end
endmodule

// File: rtl/selchk_fsm.sv
module selchk_fsm
  import selchk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic bound_ok,
  input  logic rd_ready,
  input  logic rsp_valid,
  output logic req_ready,
  output logic rd_valid,
  output logic cap_req,
  output logic cap_desc,
  output logic set_fail,
  output logic set_eval,
  output logic done
);
  st_e  st, st_n;
  logic issued;

  always_comb begin
    st_n = st;
    unique case (st)
      ST_IDLE:  if (req_valid) st_n = ST_BOUND;
      ST_BOUND: st_n = bound_ok ? ST_FETCH : ST_DONE;
      ST_FETCH: if (issued && rsp_valid) st_n = ST_EVAL;
      ST_EVAL:  st_n = ST_DONE;
      default:  st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      issued <= 1'b0;
    end else begin
      st <= st_n;
      if (st != ST_FETCH)             issued <= 1'b0;
      else if (rd_valid && rd_ready)  issued <= 1'b1;
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign rd_valid  = (st == ST_FETCH) && !issued;
  assign cap_req   = (st == ST_IDLE) && req_valid;
  assign cap_desc  = (st == ST_FETCH) && issued && rsp_valid;
  assign set_fail  = (st == ST_BOUND) && !bound_ok;
  assign set_eval  = (st == ST_EVAL);
  assign done      = (st == ST_DONE);
endmodule

// File: rtl/selchk_unit.sv
module selchk_unit #(
  parameter int SEL_W = 16,
  parameter int LIM_W = 16,
  parameter int OUT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [SEL_W-1:0] req_sel,
  input  logic [1:0]       req_cpl,
  input  logic [LIM_W-1:0] gtab_limit,
  input  logic [LIM_W-1:0] ltab_limit,
  output logic             dsc_rd_valid,
  input  logic             dsc_rd_ready,
  output logic             dsc_rd_tbl,
  output logic [SEL_W-4:0] dsc_rd_idx,
  input  logic             dsc_rsp_valid,
  input  logic [63:0]      dsc_rsp_data,
  output logic             done,
  output logic             zf,
  output logic [OUT_W-1:0] limit_out
);
  logic [1:0]       op_q, cpl_q;
  logic [SEL_W-1:0] sel_q;
  logic [63:0]      desc_q;
  logic             zf_q;
  logic [OUT_W-1:0] lim_q;
  logic             bound_ok, pass;
  logic [OUT_W-1:0] lim_calc;
  logic             cap_req, cap_desc, set_fail, set_eval;

  selchk_bound #(.SEL_W(SEL_W), .LIM_W(LIM_W)) u_bound (
    .sel(sel_q), .gtab_limit(gtab_limit), .ltab_limit(ltab_limit), .ok(bound_ok)
  );

  selchk_decode #(.OUT_W(OUT_W)) u_dec (
    .op(op_q), .desc(desc_q), .cpl(cpl_q), .rpl(sel_q[1:0]),
    .pass(pass), .lim_out(lim_calc)
  );

  selchk_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .bound_ok(bound_ok),
    .rd_ready(dsc_rd_ready), .rsp_valid(dsc_rsp_valid),
    .req_ready(req_ready), .rd_valid(dsc_rd_valid),
    .cap_req(cap_req), .cap_desc(cap_desc), .set_fail(set_fail),
    .set_eval(set_eval), .done(done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= '0;
      cpl_q  <= '0;
      sel_q  <= '0;
      desc_q <= '0;
      zf_q   <= 1'b0;
      lim_q  <= '0;
    end else begin
      if (cap_req) begin
        op_q  <= req_op;
        cpl_q <= req_cpl;
        sel_q <= req_sel;
      end
      if (cap_desc) desc_q <= dsc_rsp_data;
      if (set_fail) begin
        zf_q  <= 1'b0;
        lim_q <= '0;
      end else if (set_eval) begin
        zf_q  <= pass;
        lim_q <= lim_calc;
      end
    end
  end

  assign dsc_rd_tbl = sel_q[2];
  assign dsc_rd_idx = sel_q[SEL_W-1:3];
  assign zf         = zf_q;
  assign limit_out  = lim_q;
endmodule

// File: rtl/selchk_unit_chk.sv
module selchk_unit_chk #(
  parameter int SEL_W = 16,
  parameter int OUT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [SEL_W-1:0] req_sel,
  input logic             dsc_rd_valid,
  input logic             dsc_rd_ready,
  input logic             dsc_rd_tbl,
  input logic [SEL_W-4:0] dsc_rd_idx,
  input logic             done,
  input logic             zf,
  input logic [OUT_W-1:0] limit_out
);
  // R1
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready);
  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsc_rd_valid && !dsc_rd_ready) |=>
      (dsc_rd_valid && $stable(dsc_rd_idx) && $stable(dsc_rd_tbl)));
  // R4
  one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsc_rd_valid && dsc_rd_ready) |=> !dsc_rd_valid);
  // R10
  limit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !zf) |-> (limit_out == '0));
  // R2
  null_fast_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_sel[SEL_W-1:2] == '0)) |=>
      (!dsc_rd_valid ##1 (done && !zf)));
endmodule

bind selchk_unit selchk_unit_chk #(.SEL_W(SEL_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_sel(req_sel), .dsc_rd_valid(dsc_rd_valid), .dsc_rd_ready(dsc_rd_ready),
  .dsc_rd_tbl(dsc_rd_tbl), .dsc_rd_idx(dsc_rd_idx), .done(done), .zf(zf),
  .limit_out(limit_out)
);

// File: tb/test_selchk_unit.sv
module test_selchk_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = '0;
  logic [15:0] req_sel = '0;
  logic [1:0]  req_cpl = '0;
  logic [15:0] gtab_limit = 16'h00FF;
  logic [15:0] ltab_limit = 16'h003F;
  logic        dsc_rd_valid;
  logic        dsc_rd_ready = 1'b0;
  logic        dsc_rd_tbl;
  logic [12:0] dsc_rd_idx;
  logic        dsc_rsp_valid = 1'b0;
  logic [63:0] dsc_rsp_data = '0;
  logic        done;
  logic        zf;
  logic [31:0] limit_out;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  selchk_unit i_selchk_unit (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog act=%0d exp<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [3:0] typ, input bit cd,
                                     input logic [1:0] dpl, input bit g,
                                     input logic [19:0] raw);
    logic [63:0] d = '0;
    d[15:0]  = raw[15:0];
    d[51:48] = raw[19:16];
    d[43:40] = typ;
    d[44]    = cd;
    d[46:45] = dpl;
    d[47]    = 1'b1;
    d[55]    = g;
    return d;
  endfunction

  // Reference outcome from the requirement text
  task automatic ref_q(input int op, input logic [15:0] sel, input int cpl,
                       input logic [63:0] d, output bit fetch, output bit rz,
                       output logic [31:0] rl);
    int idx = sel[15:3];
    int lim = sel[2] ? ltab_limit : gtab_limit;
    int typ = d[43:40];
    bit cd = d[44];
    int dpl = d[46:45];
    int rpl = sel[1:0];
    int epl = (cpl > rpl) ? cpl : rpl;
    bit tok, vis;
    int raw = {d[51:48], d[15:0]};
    fetch = !(idx == 0 && sel[2] == 0) && (idx * 8 + 7 <= lim);
    rz = 0;
    rl = 0;
    if (!fetch) return;
    case (op)
      0: tok = cd || !(typ == 6 || typ == 7 || typ == 14 || typ == 15);
      1: tok = cd && (typ < 8 || typ[1]);
      2: tok = cd && typ < 8 && typ[1];
      default: tok = cd || typ == 1 || typ == 2 || typ == 3 || typ == 9 || typ == 11;
    endcase
    vis = (cd && typ >= 12) || (dpl >= epl);
    rz = tok && vis;
    if (rz && op == 3) rl = d[55] ? raw * 4096 + 4095 : raw;
  endtask

  task automatic run(input int op, input logic [15:0] sel, input int cpl,
                     input logic [63:0] d, input int s, input int dl,
                     input string tag);
    bit fetch, rz;
    logic [31:0] rl;
    int expl;
    ref_q(op, sel, cpl, d, fetch, rz, rl);
    expl = fetch ? 3 + s + dl : 1;
    @(negedge clk);
    chk(req_ready == 1'b1, {tag, " R1 ready idle"}, req_ready, 1);
    req_valid = 1'b1;
    req_op = op[1:0];
    req_sel = sel;
    req_cpl = cpl[1:0];
    @(posedge clk);
    for (int e = 0; e <= expl + 1; e++) begin
      @(negedge clk);
      if (e == 0) begin
        req_sel = 16'hFFFF;
        req_op = ~req_op;
      end
      if (e == expl) req_valid = 1'b0;
      chk(done == (e == expl), {tag, " R11 done timing"}, done, e == expl);
      chk(req_ready == (e == expl + 1), {tag, " R1 back-pressure"}, req_ready,
          e == expl + 1);
      chk(dsc_rd_valid == (fetch && e >= 1 && e <= 1 + s),
          {tag, " R4 R2 R3 read request"}, dsc_rd_valid, fetch && e >= 1 && e <= 1 + s);
      if (fetch && e == 1 + s)
        chk({dsc_rd_tbl, dsc_rd_idx} == {sel[2], sel[15:3]}, {tag, " R4 address"},
            {dsc_rd_tbl, dsc_rd_idx}, {sel[2], sel[15:3]});
      if (e == expl) begin
        chk(zf == rz, {tag, " zf"}, zf, rz);
        chk(limit_out == rl, {tag, " R10 limit"}, limit_out, rl);
      end
      dsc_rd_ready  = fetch && (e == 1 + s);
      dsc_rsp_valid = fetch && (e == 1 + s + dl);
      dsc_rsp_data  = dsc_rsp_valid ? d : 64'hDEAD_BEEF_0BAD_F00D;
      @(posedge clk);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !done && !zf && limit_out == 0 && !dsc_rd_valid,
        "reset state", {req_ready, done, zf, dsc_rd_valid}, 4'b1000);

    // R2 null selector, any requested level
    run(0, 16'h0000, 0, mk(4'h2, 1, 3, 0, 20'h10), 0, 1, "R2 null");
    run(3, 16'h0003, 0, mk(4'h2, 1, 3, 0, 20'h10), 0, 1, "R2 null rpl3");
    // R3 bounds: global limit 0xFF -> index 31 last; local 0x3F -> index 7 last
    run(0, {13'd31, 3'b000}, 0, mk(4'h2, 1, 0, 0, 0), 0, 1, "R3 gdt edge pass");
    run(0, {13'd32, 3'b000}, 0, mk(4'h2, 1, 0, 0, 0), 0, 1, "R3 gdt over");
    run(0, {13'd7, 3'b100}, 0, mk(4'h2, 1, 0, 0, 0), 1, 2, "R3 ldt edge pass");
    run(0, {13'd8, 3'b100}, 0, mk(4'h2, 1, 0, 0, 0), 0, 1, "R3 ldt over");
    run(0, {13'd0, 3'b100}, 0, mk(4'hA, 1, 0, 0, 0), 0, 1, "R3 ldt index0");
    // R6 rights query with R5 layout
    run(0, {13'd3, 3'b000}, 0, mk(4'hA, 1, 0, 0, 0), 2, 1, "R6 code");
    run(0, {13'd3, 3'b000}, 0, mk(4'hE, 0, 3, 0, 0), 0, 3, "R6 int gate");
    run(0, {13'd3, 3'b000}, 0, mk(4'hF, 0, 3, 0, 0), 4, 1, "R6 trap gate");
    run(0, {13'd3, 3'b000}, 0, mk(4'h7, 0, 3, 0, 0), 0, 1, "R6 16b trap gate");
    run(0, {13'd3, 3'b000}, 0, mk(4'hC, 0, 3, 0, 0), 0, 1, "R6 call gate");
    // R7 limit query
    run(3, {13'd5, 3'b000}, 0, mk(4'h2, 1, 0, 0, 20'hABCDE), 0, 1, "R7 R10 data g0");
    run(3, {13'd5, 3'b000}, 0, mk(4'h2, 1, 0, 1, 20'h00012), 3, 2, "R7 R10 data g1");
    run(3, {13'd5, 3'b000}, 0, mk(4'h9, 0, 0, 0, 20'h00067), 0, 1, "R7 tss");
    run(3, {13'd5, 3'b000}, 0, mk(4'h2, 0, 0, 0, 20'h00FFF), 0, 1, "R7 ldt");
    run(3, {13'd5, 3'b000}, 0, mk(4'hC, 0, 3, 0, 20'h00FFF), 0, 1, "R7 call gate");
    // R8 verify checks
    run(1, {13'd6, 3'b000}, 0, mk(4'h8, 1, 0, 0, 0), 0, 1, "R8 exec-only");
    run(1, {13'd6, 3'b000}, 0, mk(4'hA, 1, 0, 0, 0), 0, 1, "R8 readable code");
    run(1, {13'd6, 3'b000}, 0, mk(4'h0, 1, 0, 0, 0), 0, 1, "R8 ro data read");
    run(2, {13'd6, 3'b000}, 0, mk(4'h0, 1, 0, 0, 0), 0, 1, "R8 ro data write");
    run(2, {13'd6, 3'b000}, 0, mk(4'h2, 1, 0, 0, 0), 5, 4, "R8 rw data write");
    run(2, {13'd6, 3'b000}, 0, mk(4'hA, 1, 3, 0, 0), 0, 1, "R8 code write");
    run(1, {13'd6, 3'b000}, 0, mk(4'h9, 0, 3, 0, 0), 0, 1, "R8 system read");
    // R9 visibility
    run(0, {13'd4, 3'b011}, 0, mk(4'h2, 1, 2, 0, 0), 0, 1, "R9 rpl above dpl");
    run(0, {13'd4, 3'b000}, 3, mk(4'h2, 1, 2, 0, 0), 0, 1, "R9 cpl above dpl");
    run(0, {13'd4, 3'b010}, 1, mk(4'h2, 1, 2, 0, 0), 0, 1, "R9 equal pass");
    run(1, {13'd4, 3'b011}, 3, mk(4'hE, 1, 0, 0, 0), 0, 1, "R9 conforming skip");
    run(3, {13'd4, 3'b011}, 3, mk(4'h9, 0, 0, 0, 20'h67), 0, 1, "R9 system vis");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule